// File: doc/BRIEF.md
# Tiled Address Channel Swizzler

This block sits on a byte-address stream between a linear-access requester and memory. When a buffer is stored tiled, the graphics reader decodes channel-interleaved memory with a rule that differs from the requester's linear view. To make the two views agree, bit 6 of each address must be flipped by the XOR of a few higher address bits. A small decoder reads a memory-controller configuration word and picks a fold rule for each tiling type (X or Y). A selector applies the rule for the tiling type in use. A one-entry register stage then returns the rewritten address.

The decoder has two detection paths. The first reads a channel-layout field and two interleave flags. The second compares the populated sizes of two channels. Some combinations give no trustworthy rule. In that case the block raises a flag saying tiling is disallowed and passes addresses through untouched. Linear accesses are never rewritten.

The address stream is valid/ready. A beat is accepted when `in_valid` and `in_ready` are both high on a rising edge. The rewritten address appears on `out_addr` with `out_valid` one cycle later. It stays there unchanged until `out_ready` is seen high. `in_ready` is high whenever the stage is empty or is draining in that same cycle, so the block keeps full throughput. Beats leave in the order they were accepted. The fold rule applied to a beat is the one that is active in the cycle the beat is accepted.

Top module: `tile_swizzler`

## Requirements
- R1: With `det_sel`=0 and a word that is not all ones, layout field `cfg_word[1:0]` = 0 (single channel) or 1 (dual asymmetric) gives mode 0 (none) for both X and Y tiling, whatever the flag bits are.
- R2: With `det_sel`=0 and layout 2 (dual interleaved), when `cfg_word[4]` (channel XOR off) is 1, X tiling gives mode 2 (bits 9,10) and Y tiling gives mode 1 (bit 9). This holds regardless of `cfg_word[5]`.
- R3: With `det_sel`=0, layout 2 and `cfg_word[4]`=0, X gives mode 4 (9,10,11) and Y gives mode 3 (9,11) when `cfg_word[5]`=0. When `cfg_word[5]`=1, X gives mode 6 (9,10,17) and Y gives mode 5 (9,17).
- R4: With `det_sel`=0, a word of all ones gives mode 7 (unknown) for both tiling types. Layout 3 also gives mode 7.
- R5: With `det_sel`=1, when `cfg_word[15:0]` equals `cfg_word[31:16]`, X gives mode 2 and Y gives mode 1. When they differ, both give mode 0. The all-ones rule does not apply on this path.
- R6: `tile_kind` codes are 0 linear, 1 X, 2 Y and 3 treated as linear. `mode_o` shows the mode of the selected tiling type, and 0 for linear. `tiling_disallowed` is 1 exactly when the tiling type is X or Y and `mode_o` is 7.
- R7: For an accepted beat, bit 6 of the output equals input bit 6 XOR the folded bits. Bit 9 is folded in modes 1 to 6. Bit 10 is folded in modes 2, 4 and 6. Bit 11 is folded in modes 3 and 4. Bit 17 is folded in modes 5 and 6. All other bits are copied unchanged.
- R8: A beat accepted while the tiling type is linear, or while the mode is 7, is output unchanged.
- R9: A beat accepted on one edge is presented with `out_valid` on the next edge. Beats leave in acceptance order, and none is lost or duplicated.
- R10: `in_ready` is high exactly when the stage is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_addr` hold.
- R11: While `rst_n` is low and after its release, `out_valid` is 0 until a beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_word | input | CFG_W (32) | Memory-controller configuration word |
| det_sel | input | 1 | 0 selects layout/flag decoding, 1 selects channel-size comparison |
| tile_kind | input | 2 | Tiling type: 0 linear, 1 X, 2 Y, 3 linear |
| mode_o | output | 3 | Fold mode for the selected tiling type |
| tiling_disallowed | output | 1 | The selected tiled layout has no usable rule |
| in_valid | input | 1 | Input address valid |
| in_ready | output | 1 | Block can accept an address |
| in_addr | input | ADDR_W (32) | Input byte address |
| out_valid | output | 1 | Rewritten address valid |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | ADDR_W (32) | Rewritten byte address |

## Verification
In a single cycle the stage can drain its held beat and accept a new one. In that same cycle the configuration or the tiling type may also change, so the new beat must take the mode that is active at acceptance while the beat already held keeps its value. The bench provokes this by making `out_ready` pseudo-random under a continuous stream. In one phase it also changes the configuration and the tiling type every cycle. A reference queue model is compared with `out_valid`, `out_addr` and `in_ready` on every clock. Its expected addresses are built from the fold rules, and the mode tables are checked with constants taken from the requirements.

// File: rtl/tswz_pkg.sv
package tswz_pkg;

  typedef enum logic [2:0] {
    SWZ_NONE     = 3'd0,
    SWZ_9        = 3'd1,
    SWZ_9_10     = 3'd2,
    SWZ_9_11     = 3'd3,
    SWZ_9_10_11  = 3'd4,
    SWZ_9_17     = 3'd5,
    SWZ_9_10_17  = 3'd6,
    SWZ_UNKNOWN  = 3'd7
  } swz_mode_e;

  typedef enum logic [1:0] {
    TILE_LINEAR = 2'd0,
    TILE_X      = 2'd1,
    TILE_Y      = 2'd2,
    TILE_RSVD   = 2'd3
  } tile_kind_e;

  typedef enum logic [1:0] {
    LAYOUT_SINGLE = 2'd0,
    LAYOUT_ASYM   = 2'd1,
    LAYOUT_INTLV  = 2'd2,
    LAYOUT_RSVD   = 2'd3
  } layout_e;

  // configuration word field positions
  localparam int LAYOUT_LSB  = 0;
  localparam int XOR_OFF_BIT = 4;
  localparam int SEL17_BIT   = 5;

  // address bit that receives the fold
  localparam int SWZ_BIT = 6;

  typedef struct packed {
    logic f9;
    logic f10;
    logic f11;
    logic f17;
  } fold_t;

  function automatic fold_t mode_folds(swz_mode_e m);
    fold_t f;
    f = '0;
    case (m)
      SWZ_9:       f.f9 = 1'b1;
      SWZ_9_10:    begin f.f9 = 1'b1; f.f10 = 1'b1; end
      SWZ_9_11:    begin f.f9 = 1'b1; f.f11 = 1'b1; end
      SWZ_9_10_11: begin f.f9 = 1'b1; f.f10 = 1'b1; f.f11 = 1'b1; end
      SWZ_9_17:    begin f.f9 = 1'b1; f.f17 = 1'b1; end
      SWZ_9_10_17: begin f.f9 = 1'b1; f.f10 = 1'b1; f.f17 = 1'b1; end
      default:     f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/tswz_cfg_decode.sv
module tswz_cfg_decode
  import tswz_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter int SZ_W  = 16
) (
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             det_sel,
  output swz_mode_e        mode_x,
  output swz_mode_e        mode_y
);

  logic [SZ_W-1:0] size_a;
  logic [SZ_W-1:0] size_b;
  layout_e         layout;
  logic            xor_off;
  logic            sel17;
  logic            all_ones;

  assign size_a   = cfg_word[SZ_W-1:0];
  assign size_b   = cfg_word[2*SZ_W-1:SZ_W];
  assign layout   = layout_e'(cfg_word[LAYOUT_LSB +: 2]);
  assign xor_off  = cfg_word[XOR_OFF_BIT];
  assign sel17    = cfg_word[SEL17_BIT];
  assign all_ones = &cfg_word;

  always_comb begin
    mode_x = SWZ_NONE;
    mode_y = SWZ_NONE;
    if (det_sel) begin
      if (size_a == size_b) begin
        mode_x = SWZ_9_10;
        mode_y = SWZ_9;
      end
    end else if (all_ones) begin
      mode_x = SWZ_UNKNOWN;
      mode_y = SWZ_UNKNOWN;
    end else begin
      case (layout)
        LAYOUT_SINGLE, LAYOUT_ASYM: begin
          mode_x = SWZ_NONE;
          mode_y = SWZ_NONE;
        end
        LAYOUT_INTLV: begin
          if (xor_off) begin
            mode_x = SWZ_9_10;
            mode_y = SWZ_9;
          end else if (sel17) begin
            mode_x = SWZ_9_10_17;
            mode_y = SWZ_9_17;
          end else begin
            mode_x = SWZ_9_10_11;
            mode_y = SWZ_9_11;
          end
        end
        default: begin
          mode_x = SWZ_UNKNOWN;
          mode_y = SWZ_UNKNOWN;
        end
      endcase
    end
  end

endmodule

// File: rtl/tswz_mode_select.sv
module tswz_mode_select
  import tswz_pkg::*;
(
  input  logic [1:0] tile_kind,
  input  swz_mode_e  mode_x,
  input  swz_mode_e  mode_y,
  output swz_mode_e  mode,
  output logic       disallow
);

  always_comb begin
    case (tile_kind_e'(tile_kind))
      TILE_X:  mode = mode_x;
      TILE_Y:  mode = mode_y;
      default: mode = SWZ_NONE;
    endcase
  end

  assign disallow = (mode == SWZ_UNKNOWN);

endmodule

// File: rtl/tswz_xlate.sv
module tswz_xlate
  import tswz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  swz_mode_e         mode,
  output logic [ADDR_W-1:0] addr_o
);

  fold_t folds;
  logic  term17;

  assign folds = mode_folds(mode);

  generate
    if (ADDR_W > 17) begin : g_b17
      assign term17 = folds.f17 & addr_i[17];
    end else begin : g_no_b17
      assign term17 = 1'b0;
    end
  endgenerate

  always_comb begin
    addr_o = addr_i;
    addr_o[SWZ_BIT] = addr_i[SWZ_BIT]
                    ^ (folds.f9  & addr_i[9])
                    ^ (folds.f10 & addr_i[10])
                    ^ (folds.f11 & addr_i[11])
                    ^ term17;
  end

endmodule

// File: rtl/tswz_stage.sv
module tswz_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         held_v;
  logic [W-1:0] held_d;

  assign in_ready  = !held_v || out_ready;
  assign out_valid = held_v;
  assign out_data  = held_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_v <= 1'b0;
      held_d <= '0;
    end else begin
      if (in_ready) held_v <= in_valid;
      if (in_valid && in_ready) held_d <= in_data;
    end
  end

endmodule

// File: rtl/tile_swizzler.sv
module tile_swizzler
  import tswz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CFG_W  = 32,
  parameter int SZ_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              det_sel,
  input  logic [1:0]        tile_kind,
  output logic [2:0]        mode_o,
  output logic              tiling_disallowed,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);

  swz_mode_e         mode_x;
  swz_mode_e         mode_y;
  swz_mode_e         mode_sel;
  logic              disallow;
  logic [ADDR_W-1:0] xl_addr;

  tswz_cfg_decode #(.CFG_W(CFG_W), .SZ_W(SZ_W)) u_dec (
    .cfg_word (cfg_word),
    .det_sel  (det_sel),
    .mode_x   (mode_x),
    .mode_y   (mode_y)
  );

  tswz_mode_select u_sel (
    .tile_kind (tile_kind),
    .mode_x    (mode_x),
    .mode_y    (mode_y),
    .mode      (mode_sel),
    .disallow  (disallow)
  );

  tswz_xlate #(.ADDR_W(ADDR_W)) u_xl (
    .addr_i (in_addr),
    .mode   (mode_sel),
    .addr_o (xl_addr)
  );

  tswz_stage #(.W(ADDR_W)) u_stg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (xl_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_addr)
  );

  assign mode_o            = mode_sel;
  assign tiling_disallowed = disallow;

endmodule

// File: rtl/tile_swizzler_chk.sv
module tile_swizzler_chk #(
  parameter int ADDR_W = 32,
  parameter int CFG_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CFG_W-1:0]  cfg_word,
  input logic              det_sel,
  input logic [1:0]        tile_kind,
  input logic [2:0]        mode_o,
  input logic              tiling_disallowed,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr
);

  localparam logic [ADDR_W-1:0] KEEP_MASK = ~(ADDR_W'(1) << 6);

  logic tiled;
  assign tiled = (tile_kind == 2'd1) || (tile_kind == 2'd2);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr));

  p_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_upper_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> (out_addr & KEEP_MASK) == ($past(in_addr) & KEEP_MASK));

  p_linear_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !tiled |=> out_addr == $past(in_addr));

  p_unknown_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && tiling_disallowed |=> out_addr == $past(in_addr));

  p_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tiling_disallowed |-> tiled && mode_o == 3'd7);

  p_linear_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tiled |-> mode_o == 3'd0 && !tiling_disallowed);

  p_all_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !det_sel && (&cfg_word) && tiled |-> tiling_disallowed);

  p_size_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    det_sel && tiled |-> mode_o <= 3'd2);

  p_reset_idle_r11: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

bind tile_swizzler tile_swizzler_chk #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .cfg_word          (cfg_word),
  .det_sel           (det_sel),
  .tile_kind         (tile_kind),
  .mode_o            (mode_o),
  .tiling_disallowed (tiling_disallowed),
  .in_valid          (in_valid),
  .in_ready          (in_ready),
  .in_addr           (in_addr),
  .out_valid         (out_valid),
  .out_ready         (out_ready),
  .out_addr          (out_addr)
);

// File: tb/tile_swizzler_tb.sv
`timescale 1ns/100ps
module tile_swizzler_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = 32'h0;
  logic        det_sel = 1'b0;
  logic [1:0]  tile_kind = 2'd0;
  logic [2:0]  mode_o;
  logic        tiling_disallowed;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = 32'h0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_addr;

  int checks = 0;
  int fails  = 0;
  bit mon_en = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  logic [31:0] exp_q[$];
  bit          pass_q[$];

  always #2 clk = ~clk;

  tile_swizzler u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .det_sel(det_sel),
    .tile_kind(tile_kind), .mode_o(mode_o), .tiling_disallowed(tiling_disallowed),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr)
  );

  function automatic int ref_mode(bit det, logic [31:0] cw, logic [1:0] kind);
    bit is_x;
    if (kind != 2'd1 && kind != 2'd2) return 0;
    is_x = (kind == 2'd1);
    if (det) return (cw[15:0] == cw[31:16]) ? (is_x ? 2 : 1) : 0;
    if (cw == 32'hFFFF_FFFF) return 7;
    case (cw[1:0])
      2'd0, 2'd1: return 0;
      2'd2: begin
        if (cw[4]) return is_x ? 2 : 1;
        if (cw[5]) return is_x ? 6 : 5;
        return is_x ? 4 : 3;
      end
      default: return 7;
    endcase
  endfunction

  function automatic logic [31:0] ref_addr(logic [31:0] a, int m);
    logic [31:0] r;
    logic b;
    r = a;
    b = a[6];
    if (m >= 1 && m <= 6) b = b ^ a[9];
    if (m == 2 || m == 4 || m == 6) b = b ^ a[10];
    if (m == 3 || m == 4) b = b ^ a[11];
    if (m == 5 || m == 6) b = b ^ a[17];
    r[6] = b;
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step_seed();
    seed = seed * 32'd1664525 + 32'd1013904223;
  endtask

  // monitor: runs 1 ns before each rising edge
  initial begin : monitor
    bit          exp_v;
    bit          acc;
    int          m;
    forever begin
      @(negedge clk);
      #1;
      if (mon_en) begin
        exp_v = (exp_q.size() != 0);
        check("R9 out_valid", {31'd0, out_valid}, {31'd0, exp_v});
        if (exp_v && out_valid)
          check(pass_q[0] ? "R8 out_addr" : "R7 out_addr", out_addr, exp_q[0]);
        check("R10 in_ready", {31'd0, in_ready}, {31'd0, (!exp_v || out_ready)});
        acc = in_valid && (!exp_v || out_ready);
        if (exp_v && out_ready) begin
          void'(exp_q.pop_front());
          void'(pass_q.pop_front());
        end
        if (acc) begin
          m = ref_mode(det_sel, cfg_word, tile_kind);
          exp_q.push_back(ref_addr(in_addr, m));
          pass_q.push_back(m == 0 || m == 7);
        end
      end
    end
  end

  task automatic check_modes(string tag, bit det, logic [31:0] cw, int ex, int ey);
    @(negedge clk);
    in_valid = 1'b0;
    det_sel  = det;
    cfg_word = cw;
    tile_kind = 2'd1;
    #0.1;
    check({tag, " X mode"}, {29'd0, mode_o}, ex);
    check("R6 X flag", {31'd0, tiling_disallowed}, {31'd0, (ex == 7)});
    tile_kind = 2'd2;
    #0.1;
    check({tag, " Y mode"}, {29'd0, mode_o}, ey);
    check("R6 Y flag", {31'd0, tiling_disallowed}, {31'd0, (ey == 7)});
    tile_kind = 2'd0;
    #0.1;
    check("R6 linear mode", {29'd0, mode_o}, 0);
    check("R6 linear flag", {31'd0, tiling_disallowed}, 0);
    tile_kind = 2'd3;
    #0.1;
    check("R6 kind3 mode", {29'd0, mode_o}, 0);
  endtask

  task automatic run_phase(bit det, logic [31:0] cw, logic [1:0] kind, int n, bit hop);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      step_seed();
      if (hop) begin
        case (seed[31:29])
          3'd0: cw = 32'h0000_0012;
          3'd1: cw = 32'h0000_0002;
          3'd2: cw = 32'h0000_0022;
          3'd3: cw = 32'hFFFF_FFFF;
          3'd4: cw = 32'h0000_0001;
          default: cw = 32'h0000_0032;
        endcase
        kind = seed[28:27];
        det  = seed[26] & seed[25];
      end
      det_sel   = det;
      cfg_word  = cw;
      tile_kind = kind;
      in_valid  = seed[0] | seed[1];
      out_ready = (seed[3:2] != 2'b00);
      in_addr   = seed ^ {seed[15:0], seed[31:16]};
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    #(4 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    #1;
    check("R11 reset out_valid", {31'd0, out_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    @(negedge clk);
    #1.5;
    check("R11 idle after reset", {31'd0, out_valid}, 0);

    check_modes("R1 single",        1'b0, 32'h0000_0000, 0, 0);
    check_modes("R1 asym",          1'b0, 32'h0000_0001, 0, 0);
    check_modes("R1 asym flags",    1'b0, 32'h0000_0031, 0, 0);
    check_modes("R2 xor off",       1'b0, 32'h0000_0012, 2, 1);
    check_modes("R2 xor off sel17", 1'b0, 32'h0000_0032, 2, 1);
    check_modes("R3 bit11",         1'b0, 32'h0000_0002, 4, 3);
    check_modes("R3 bit17",         1'b0, 32'h0000_0022, 6, 5);
    check_modes("R4 all ones",      1'b0, 32'hFFFF_FFFF, 7, 7);
    check_modes("R4 layout3",       1'b0, 32'h0000_0003, 7, 7);
    check_modes("R5 equal",         1'b1, 32'h1234_1234, 2, 1);
    check_modes("R5 unequal",       1'b1, 32'h1235_1234, 0, 0);
    check_modes("R5 all ones",      1'b1, 32'hFFFF_FFFF, 2, 1);

    run_phase(1'b0, 32'h0000_0012, 2'd1, 60, 1'b0);
    run_phase(1'b0, 32'h0000_0012, 2'd2, 60, 1'b0);
    run_phase(1'b0, 32'h0000_0002, 2'd1, 60, 1'b0);
    run_phase(1'b0, 32'h0000_0002, 2'd2, 60, 1'b0);
    run_phase(1'b0, 32'h0000_0022, 2'd1, 60, 1'b0);
    run_phase(1'b0, 32'h0000_0022, 2'd2, 60, 1'b0);
    run_phase(1'b0, 32'hFFFF_FFFF, 2'd1, 40, 1'b0);
    run_phase(1'b0, 32'h0000_0022, 2'd0, 40, 1'b0);
    run_phase(1'b1, 32'hABCD_ABCD, 2'd1, 40, 1'b0);
    run_phase(1'b0, 32'h0000_0000, 2'd1, 200, 1'b1);

    // long stall with a waiting beat: R10 hold
    @(negedge clk);
    det_sel = 1'b0; cfg_word = 32'h0000_0022; tile_kind = 2'd1;
    in_valid = 1'b1; in_addr = 32'h0002_0E40; out_ready = 1'b0;
    @(negedge clk);
    in_addr = 32'h0000_0600;
    repeat (5) @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1.5;
    check("R9 drained", {31'd0, out_valid}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule